// File: doc/BRIEF.md
# Pipelined Boolean Satisfiability Engine

This block searches for a satisfying assignment of a CNF formula whose number of variables and clauses is fixed at elaboration (8 variables and 16 clauses by default). Before a run, software-side logic fills two tables through simple write ports. The effect table holds, for every variable and polarity, a per-clause pair of bits: "this literal satisfies the clause" and "this literal is knocked out of the clause". The clause table holds, for every clause, a mask of the variables that appear in it.

A start pulse launches a depth-first search. Every decision travels once around a five-stage ring: choose a variable, read its effect row, update the clause state, look for a falsified clause, and read that clause's variable mask. When a clause is falsified, the variables it names form a conflict pool. The engine jumps back to the highest-indexed variable at or below the top of that pool whose second polarity has not yet been tried. When the run finishes, `done` pulses and the verdict and the solution are held until the next start.

Top module: `pipe_sat_solver`

## Requirements
- R1: Table writes (`eff_we` and `cls_we`) take effect only while the engine is idle. Writes presented while `busy` is high leave both tables unchanged.
- R2: A `start` sampled while idle begins a run and raises `busy` on the next cycle. A `start` sampled while busy has no effect on the run.
- R3: `done` is high for exactly one cycle, in the same cycle that `busy` falls. `sat` and `sol` then hold their values until the next accepted start, which clears both to 0.
- R4: Each decision takes exactly five cycles. A run that makes D decisions and ends satisfied raises `done` 5·D cycles after the start edge. A run that ends unsatisfiable raises `done` 5·D+1 cycles after that edge.
- R5: Variables are decided in index order, starting from 0. A variable that is newly decided is first given the value 0.
- R6: A clause is falsified when it is not satisfied and none of its variables is still unassigned. On a conflict, the lowest-numbered falsified clause supplies the pool. The variable selected is the highest index, no greater than the highest variable in the pool, that has not yet been set to 1 by a flip. That variable is flipped to 1, and every variable above it is freed.
- R7: The result is unsatisfiable (`sat`=0, `sol`=0) when the conflict pool is empty or no variable qualifies for a flip.
- R8: The result is satisfiable (`sat`=1) once every clause is satisfied, or once all variables are assigned with no conflict. `sol` bit i is the value of variable i, and unassigned variables read 0. The solution is therefore the lexicographically first model, with variable 0 as the most significant and 0 ordered before 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| eff_we | input | 1 | Write one effect-table row |
| eff_var | input | VW | Variable index of the row |
| eff_pol | input | 1 | Polarity of the row (1 = variable true) |
| eff_sat | input | NC | Clauses satisfied by this literal |
| eff_rem | input | NC | Clauses from which this literal is removed |
| cls_we | input | 1 | Write one clause-table row |
| cls_idx | input | CW | Clause index |
| cls_vars | input | NV | Variables occurring in the clause |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| sat | output | 1 | Verdict of the last run |
| sol | output | NV | Satisfying assignment (0 if unsatisfiable) |

## Verification
The bench targets four corner cases. The first is an instance that a single decision satisfies, where a design that waits for a full assignment would report late. The second forces a flip on variable 0, which catches a wrong first polarity or a flip to the wrong value. The third is a formula that is unsatisfiable after backtracking, plus one that contains an empty clause: in these, a design that mishandles an empty pool or an exhausted flip search either hangs or reports a false model. Random 3-literal formulas are checked both against a behavioural model of the search, which gives the exact cycle of `done`, and against exhaustive enumeration. A wrong conflict-clause priority or a wrong backjump target shows up there as a different cycle count or a different model. Table writes and start pulses injected in mid-run, followed by a rerun, expose a design that does not ignore them.

// File: rtl/pipe_sat_solver.sv
`timescale 1ns/1ps
module pipe_sat_solver #(
  parameter int NV = 8,
  parameter int NC = 16,
  localparam int VW = (NV > 1) ? $clog2(NV) : 1,
  localparam int CW = (NC > 1) ? $clog2(NC) : 1,
  localparam int LW = $clog2(NV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          eff_we,
  input  logic [VW-1:0] eff_var,
  input  logic          eff_pol,
  input  logic [NC-1:0] eff_sat,
  input  logic [NC-1:0] eff_rem,
  input  logic          cls_we,
  input  logic [CW-1:0] cls_idx,
  input  logic [NV-1:0] cls_vars,
  output logic          busy,
  output logic          done,
  output logic          sat,
  output logic [NV-1:0] sol
);
  typedef enum logic [2:0] {IDLE, DEC, FET, EVA, DET, CFV} ph_t;
  ph_t ph;

  logic [2*NV-1:0][NC-1:0] esat, erem;
  logic [NC-1:0][NV-1:0]   cvars;
  logic [NV-1:0]           val, tried, pool;
  logic [VW-1:0]           lvl, cur_v, nxt, pick, pmax;
  logic                    have, cur_p, conf_q, fin_q, pick_ok;
  logic [NC-1:0]           csat, fs, fr, unsat;
  logic [NC-1:0][LW-1:0]   clive;
  logic [NV-1:0][NC-1:0]   snap_sat;
  logic [NV-1:0][NC-1:0][LW-1:0] snap_live;
  logic [CW-1:0]           cidx, cidx_q;

  assign busy = (ph != IDLE);
  assign nxt  = have ? lvl + VW'(1) : '0;

  always_comb begin
    pmax = '0;
    for (int i = 0; i < NV; i++) if (pool[i]) pmax = VW'(i);
    pick_ok = 1'b0;
    pick = '0;
    for (int i = 0; i < NV; i++)
      if ((|pool) && VW'(i) <= pmax && !tried[i]) begin
        pick_ok = 1'b1;
        pick = VW'(i);
      end
  end

  always_comb begin
    cidx = '0;
    for (int c = 0; c < NC; c++) unsat[c] = !csat[c] && (clive[c] == '0);
    for (int c = NC - 1; c >= 0; c--) if (unsat[c]) cidx = CW'(c);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= IDLE; esat <= '0; erem <= '0; cvars <= '0;
      val <= '0; tried <= '0; pool <= '0; lvl <= '0; cur_v <= '0;
      have <= 1'b0; cur_p <= 1'b0; conf_q <= 1'b0; fin_q <= 1'b0;
      csat <= '0; clive <= '0; fs <= '0; fr <= '0; cidx_q <= '0;
      snap_sat <= '0; snap_live <= '0;
      done <= 1'b0; sat <= 1'b0; sol <= '0;
    end else begin
      done <= 1'b0;
      if (eff_we && ph == IDLE) begin
        esat[{eff_var, eff_pol}] <= eff_sat;
        erem[{eff_var, eff_pol}] <= eff_rem;
      end
      if (cls_we && ph == IDLE) cvars[cls_idx] <= cls_vars;
      case (ph)
        IDLE: if (start) begin
          ph <= DEC; conf_q <= 1'b0; have <= 1'b0; lvl <= '0;
          val <= '0; tried <= '0; csat <= '0; sat <= 1'b0; sol <= '0;
          for (int c = 0; c < NC; c++) clive[c] <= LW'($countones(cvars[c]));
        end
        DEC: if (conf_q) begin
          if (!pick_ok) begin
            done <= 1'b1;
            ph <= IDLE;
          end else begin
            for (int j = 0; j < NV; j++)
              if (j > int'(pick)) begin val[j] <= 1'b0; tried[j] <= 1'b0; end
            val[pick] <= 1'b1;
            tried[pick] <= 1'b1;
            lvl <= pick; cur_v <= pick; cur_p <= 1'b1;
            ph <= FET;
          end
        end else begin
          snap_sat[nxt] <= csat;
          snap_live[nxt] <= clive;
          val[nxt] <= 1'b0; tried[nxt] <= 1'b0;
          lvl <= nxt; have <= 1'b1; cur_v <= nxt; cur_p <= 1'b0;
          ph <= FET;
        end
        FET: begin
          fs <= esat[{cur_v, cur_p}];
          fr <= erem[{cur_v, cur_p}];
          ph <= EVA;
        end
        EVA: begin
          csat <= snap_sat[cur_v] | fs;
          for (int c = 0; c < NC; c++) clive[c] <= snap_live[cur_v][c] - LW'(fr[c]);
          ph <= DET;
        end
        DET: begin
          conf_q <= |unsat;
          fin_q <= !(|unsat) && ((&csat) || lvl == VW'(NV - 1));
          cidx_q <= cidx;
          ph <= CFV;
        end
        CFV: if (fin_q) begin
          done <= 1'b1; sat <= 1'b1; sol <= val; ph <= IDLE;
        end else begin
          pool <= cvars[cidx_q];
          ph <= DEC;
        end
        default: ph <= IDLE;
      endcase
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R4
  fet_eva_chk: assert property (@(posedge clk) disable iff (!rst_n) (ph == FET) |=> (ph == EVA));
  // R4
  eva_det_chk: assert property (@(posedge clk) disable iff (!rst_n) (ph == EVA) |=> (ph == DET));
  // R2
  det_cfv_chk: assert property (@(posedge clk) disable iff (!rst_n) (ph == DET && start) |=> (ph == CFV));
  // R5
  fresh_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == DEC && !conf_q) |=> (ph == FET && !cur_p));
  // R6
  flip_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == DEC && conf_q && pick_ok) |=> (cur_p && cur_v == $past(pick)));
  // R1
  tbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cvars) && $stable(esat) && $stable(erem)));
  // R7
  unsat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && !sat) |-> (sol == '0));
endmodule

// File: tb/pipe_sat_solver_tb_top.sv
`timescale 1ns/1ps
module pipe_sat_solver_tb_top;
  localparam int NV = 8;
  localparam int NC = 16;
  localparam int VW = 3;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic eff_we = 1'b0, eff_pol = 1'b0, cls_we = 1'b0;
  logic [VW-1:0] eff_var = '0;
  logic [NC-1:0] eff_sat = '0, eff_rem = '0;
  logic [CW-1:0] cls_idx = '0;
  logic [NV-1:0] cls_vars = '0;
  logic busy, done, sat;
  logic [NV-1:0] sol;

  int checks = 0, failures = 0;
  logic [NV-1:0] pos [NC];
  logic [NV-1:0] neg [NC];

  always #2 clk = ~clk;

  pipe_sat_solver #(.NV(NV), .NC(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .eff_we(eff_we), .eff_var(eff_var), .eff_pol(eff_pol), .eff_sat(eff_sat), .eff_rem(eff_rem),
    .cls_we(cls_we), .cls_idx(cls_idx), .cls_vars(cls_vars),
    .busy(busy), .done(done), .sat(sat), .sol(sol));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit clause_sat(input int c, input logic [NV-1:0] asg, input logic [NV-1:0] a);
    return |(pos[c] & a & asg) || |(neg[c] & a & ~asg);
  endfunction

  // Search model built from R4-R8: decisions, verdict and model.
  function automatic void model(output int dec, output bit ok, output logic [NV-1:0] res);
    logic [NV-1:0] v = '0, tr = '0, am = '0, pl = '0;
    int lv = -1;
    bit cf = 0;
    dec = 0; ok = 0; res = '0;
    for (int guard = 0; guard < 5000; guard++) begin
      if (cf) begin
        int pm = -1, pk = -1;
        for (int i = 0; i < NV; i++) if (pl[i]) pm = i;
        for (int i = 0; i <= pm; i++) if (!tr[i]) pk = i;
        if (pk < 0) return;
        for (int j = pk + 1; j < NV; j++) begin v[j] = 0; tr[j] = 0; am[j] = 0; end
        v[pk] = 1; tr[pk] = 1; lv = pk;
      end else begin
        lv++; v[lv] = 0; tr[lv] = 0; am[lv] = 1;
      end
      dec++;
      begin
        bit all = 1;
        cf = 0;
        for (int c = 0; c < NC; c++) begin
          bit s = clause_sat(c, v, am);
          if (!s) all = 0;
          if (!s && !(|((pos[c] | neg[c]) & ~am)) && !cf) begin cf = 1; pl = pos[c] | neg[c]; end
        end
        if (!cf && (all || lv == NV - 1)) begin ok = 1; res = v & am; return; end
      end
    end
  endfunction

  function automatic void brute(output bit ok, output logic [NV-1:0] res);
    ok = 0; res = '0;
    for (int k = 0; k < (1 << NV); k++) begin
      logic [NV-1:0] a;
      bit all = 1;
      for (int i = 0; i < NV; i++) a[i] = k[NV-1-i];
      for (int c = 0; c < NC; c++) if (!clause_sat(c, a, '1)) all = 0;
      if (all) begin ok = 1; res = a; return; end
    end
  endfunction

  task automatic load();
    for (int v = 0; v < NV; v++)
      for (int p = 0; p < 2; p++) begin
        @(negedge clk);
        eff_we = 1; eff_var = VW'(v); eff_pol = p[0];
        for (int c = 0; c < NC; c++) begin
          eff_sat[c] = p ? pos[c][v] : neg[c][v];
          eff_rem[c] = p ? neg[c][v] : pos[c][v];
        end
      end
    for (int c = 0; c < NC; c++) begin
      @(negedge clk);
      eff_we = 0; cls_we = 1; cls_idx = CW'(c); cls_vars = pos[c] | neg[c];
    end
    @(negedge clk);
    cls_we = 0;
  endtask

  task automatic run(input bit disturb);
    int d, t;
    bit ok, bok;
    logic [NV-1:0] res, bres;
    model(d, ok, res);
    brute(bok, bres);
    t = ok ? 5 * d : 5 * d + 1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int n = 1; n <= t; n++) begin
      @(negedge clk);
      // R2 busy held through the run; R3/R4 done exactly at cycle t
      chk(busy == (n < t), "R2", "busy", busy, n < t);
      chk(done == (n == t), "R4", "done timing", done, n == t);
      if (disturb && n == 2) begin
        start = 1; eff_we = 1; eff_var = '0; eff_pol = 0; eff_sat = '1; eff_rem = '0;
        cls_we = 1; cls_idx = '0; cls_vars = '0;
      end else if (disturb && n == 3) begin
        start = 0; eff_we = 0; cls_we = 0;
      end
    end
    chk(sat == ok, "R7", "verdict vs search model", sat, ok);
    chk(sol == res, "R8", "model vs search model", sol, res);
    chk(sat == bok && sol == bres, "R8", "vs exhaustive enumeration", sol, bres);
    @(negedge clk);
    chk(!done && !busy, "R3", "done single pulse", done, 0);
    chk(sat == ok && sol == res, "R3", "result held", sol, res);
  endtask

  task automatic clear_inst();
    for (int c = 0; c < NC; c++) begin pos[c] = '0; neg[c] = '0; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "R4", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(77));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !sat && sol == '0, "R3", "reset state", sol, 0);

    // R5 R8: one decision (x0=0) satisfies all clauses
    clear_inst();
    for (int c = 0; c < NC; c++) begin neg[c][0] = 1; pos[c][(c % 7) + 1] = 1; end
    load(); run(0);

    // R6: every clause forces x0=1, needs a flip
    clear_inst();
    for (int c = 0; c < NC; c++) pos[c][0] = 1;
    load(); run(0);

    // R7: x0,x1 all four combinations forbidden
    clear_inst();
    for (int c = 0; c < NC; c++) begin
      if (c[0]) pos[c][0] = 1; else neg[c][0] = 1;
      if (c[1]) pos[c][1] = 1; else neg[c][1] = 1;
    end
    load(); run(0);

    // R7: empty clause gives an empty pool
    clear_inst();
    for (int c = 1; c < NC; c++) pos[c][c % NV] = 1;
    load(); run(0);

    // R6 R8: random 3-literal formulas; R1 R2 disturbed then rerun
    for (int r = 0; r < 40; r++) begin
      clear_inst();
      for (int c = 0; c < NC; c++)
        for (int k = 0; k < 3; k++) begin
          int vv = int'($urandom % NV);
          if (!pos[c][vv] && !neg[c][vv]) begin
            if ($urandom % 2) pos[c][vv] = 1; else neg[c][vv] = 1;
          end
        end
      load();
      run(r % 4 == 0);
      if (r % 4 == 0) run(0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule